// File: doc/BRIEF.md
# Hash Context Save/Restore Port

This block is the register window that lets software park a partly finished hash computation and pick it up later. The internal chaining state of a hash core is streamed through one fixed register address. Each successive access moves to the next state word. The number of words in a full pass depends on the selected algorithm. The same address is also used to read the finished digest: software reads only as many words as the digest needs, then rewrites the mode register to rewind the stream.

Around the chaining window the port holds four more things:
- a mode register that carries the algorithm code, an HMAC enable and a data byte-order field;
- a 64-bit count of processed message bytes, split across two 32-bit registers. It can be read and written, and the core can load it;
- a busy status bit;
- a resume indication. While the stored length is nonzero, the core must start from the words written through the chain window rather than from its initial constants.

A small controller tracks the stream position. It has two states. In `CH_IDLE` the word index is 0. An accepted chain access moves it to `CH_MID` (transition *begin*). In `CH_MID`, each accepted chain access advances the index (transition *advance*). The access to the last word of the current algorithm returns to `CH_IDLE` (transition *wrap*). A mode write also returns to `CH_IDLE` (transition *rewind*).

Top module: `hctx_port`

## Requirements
- R1: After reset, the read data, the mode fields, the length, the resume flag and every restore word are zero.
- R2: A full chain pass is 8 words for algorithm codes 0 (SHA-256), 1 (SHA-224) and 4 (SM3), and 16 words for codes 2 (SHA-384) and 3 (SHA-512). After the last word the index wraps to word 0.
- R3: Successive reads at offset 0x04 return core state words 0, 1, 2, … in order, with word k taken from bits [32k+31:32k] of `core_state_in`. The read data appears one cycle after the read.
- R4: Successive writes at offset 0x04 load restore words 0, 1, 2, … in order, with word k driven on bits [32k+31:32k] of `core_state_out`.
- R5: A write at offset 0x00 stores the mode register and returns the chain index to 0. Bits 18:16 are the algorithm code, bit 22 is the HMAC enable and bits 31:26 are the byte-order field. A read at 0x00 returns the stored value.
- R6: The length is 64 bits: the low word is at 0x60 and the high word at 0x64. Both can be read and written. A `core_len_done` pulse loads `core_len_in`, and a bus write to a length word in the same cycle takes precedence for that word.
- R7: A read at offset 0x58 returns the busy input in bit 0 and zeros in all other bits.
- R8: While `core_busy` is high, a chain write leaves every restore word unchanged, a chain read returns zero, and neither moves the chain index.
- R9: `core_resume` is high exactly when the stored 64-bit length is nonzero.
- R10: A read at any unmapped offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after a read |
| core_busy | input | 1 | Hash core is processing |
| core_state_in | input | MAX_WORDS*DATA_W | Current chaining state from the core |
| core_len_done | input | 1 | Core pulses to publish its byte count |
| core_len_in | input | 2*DATA_W | Byte count from the core |
| core_state_out | output | MAX_WORDS*DATA_W | Restore words written by software |
| core_len_out | output | 2*DATA_W | Stored processed length |
| core_resume | output | 1 | Core starts from restore words, not initial values |
| mode_algo | output | 3 | Algorithm code |
| mode_hmac | output | 1 | HMAC enable |
| mode_endian | output | 6 | Data byte-order field |

## Verification
The assertions check the following on every cycle:
- the chain index never passes the last word of the current algorithm;
- a mode write rewinds the index;
- busy chain reads give zero;
- busy chain writes leave the restore words untouched;
- the status read mirrors busy;
- a length publish from the core lands in the register.

The ordering of the streamed words, the wrap back to word 0 after 8 or 16 words, the rewind after a 7-word digest read, the write-precedence of the length words and the resume flag are shown only by the bench scenarios. In those scenarios a behavioural model is compared with the outputs every clock.

// File: rtl/hctx_pkg.sv
package hctx_pkg;

    typedef enum logic [2:0] {
        ALG_SHA256 = 3'd0,
        ALG_SHA224 = 3'd1,
        ALG_SHA384 = 3'd2,
        ALG_SHA512 = 3'd3,
        ALG_SM3    = 3'd4
    } hctx_algo_e;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_MID  = 1'b1
    } chain_state_e;

    localparam int unsigned WORDS_NARROW = 8;
    localparam int unsigned WORDS_WIDE   = 16;

    localparam int unsigned OFF_MODE   = 'h00;
    localparam int unsigned OFF_CHAIN  = 'h04;
    localparam int unsigned OFF_STATUS = 'h58;
    localparam int unsigned OFF_LEN_LO = 'h60;
    localparam int unsigned OFF_LEN_HI = 'h64;

    localparam int unsigned ALGO_LSB   = 16;
    localparam int unsigned HMAC_BIT   = 22;
    localparam int unsigned ENDIAN_LSB = 26;

    // 512-bit-state algorithms stream the wide word count
    function automatic logic algo_is_wide(input logic [2:0] code);
        return (code == ALG_SHA384) || (code == ALG_SHA512);
    endfunction

endpackage

// File: rtl/hctx_ctrl.sv
module hctx_ctrl
    import hctx_pkg::*;
#(
    parameter int unsigned MAX_WORDS = 16,
    localparam int unsigned IDX_W = $clog2(MAX_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chain_go,
    input  logic             mode_wr,
    input  logic             wide,
    output logic [IDX_W-1:0] idx,
    output chain_state_e     state
);

    chain_state_e     state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [IDX_W-1:0] last_idx;

    assign last_idx = wide ? IDX_W'(WORDS_WIDE - 1) : IDX_W'(WORDS_NARROW - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            CH_IDLE: begin
                if (chain_go) begin          // begin
                    state_d = CH_MID;
                    idx_d   = IDX_W'(1);
                end
            end
            CH_MID: begin
                if (mode_wr) begin           // rewind
                    state_d = CH_IDLE;
                    idx_d   = '0;
                end else if (chain_go) begin
                    if (idx_q == last_idx) begin  // wrap
                        state_d = CH_IDLE;
                        idx_d   = '0;
                    end else begin           // advance
                        idx_d = idx_q + IDX_W'(1);
                    end
                end
            end
        endcase
    end

    assign idx   = idx_q;
    assign state = state_q;

endmodule

// File: rtl/hctx_regs.sv
module hctx_regs #(
    parameter int unsigned DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_wr,
    input  logic                lo_wr,
    input  logic                hi_wr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                len_done,
    input  logic [2*DATA_W-1:0] len_in,
    output logic [DATA_W-1:0]   mode,
    output logic [2*DATA_W-1:0] len
);

    logic [DATA_W-1:0]   mode_q;
    logic [2*DATA_W-1:0] len_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (mode_wr) begin
            mode_q <= wdata;
        end
    end

    // bus write to a word overrides the core publish for that word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
        end else begin
            if (len_done) len_q <= len_in;
            if (lo_wr)    len_q[DATA_W-1:0]        <= wdata;
            if (hi_wr)    len_q[2*DATA_W-1:DATA_W] <= wdata;
        end
    end

    assign mode = mode_q;
    assign len  = len_q;

endmodule

// File: rtl/hctx_chain.sv
module hctx_chain #(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned MAX_WORDS = 16,
    localparam int unsigned IDX_W = $clog2(MAX_WORDS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            idx,
    input  logic [DATA_W-1:0]           wdata,
    input  logic [MAX_WORDS*DATA_W-1:0] state_in,
    output logic [MAX_WORDS*DATA_W-1:0] state_out,
    output logic [DATA_W-1:0]           rd_word
);

    for (genvar g = 0; g < MAX_WORDS; g++) begin : g_word
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (wr_en && (idx == IDX_W'(g))) begin
                word_q <= wdata;
            end
        end
        assign state_out[g*DATA_W +: DATA_W] = word_q;
    end

    assign rd_word = state_in[idx*DATA_W +: DATA_W];

endmodule

// File: rtl/hctx_port.sv
module hctx_port
    import hctx_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned MAX_WORDS = 16,
    localparam int unsigned IDX_W = $clog2(MAX_WORDS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_sel,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    input  logic                        core_busy,
    input  logic [MAX_WORDS*DATA_W-1:0] core_state_in,
    input  logic                        core_len_done,
    input  logic [2*DATA_W-1:0]         core_len_in,
    output logic [MAX_WORDS*DATA_W-1:0] core_state_out,
    output logic [2*DATA_W-1:0]         core_len_out,
    output logic                        core_resume,
    output logic [2:0]                  mode_algo,
    output logic                        mode_hmac,
    output logic [5:0]                  mode_endian
);

    logic hit_mode, hit_chain, hit_status, hit_lo, hit_hi;
    logic chain_go, mode_wr;
    logic [IDX_W-1:0]    chain_idx;
    chain_state_e        chain_state;
    logic [DATA_W-1:0]   mode_q;
    logic [2*DATA_W-1:0] len_q;
    logic [DATA_W-1:0]   chain_rd;
    logic [DATA_W-1:0]   rd_mux;
    logic [DATA_W-1:0]   rdata_q;

    assign hit_mode   = bus_sel && (bus_addr == ADDR_W'(OFF_MODE));
    assign hit_chain  = bus_sel && (bus_addr == ADDR_W'(OFF_CHAIN));
    assign hit_status = bus_sel && (bus_addr == ADDR_W'(OFF_STATUS));
    assign hit_lo     = bus_sel && (bus_addr == ADDR_W'(OFF_LEN_LO));
    assign hit_hi     = bus_sel && (bus_addr == ADDR_W'(OFF_LEN_HI));

    assign chain_go = hit_chain && !core_busy;
    assign mode_wr  = hit_mode && bus_wr;

    hctx_ctrl #(.MAX_WORDS(MAX_WORDS)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .chain_go (chain_go),
        .mode_wr  (mode_wr),
        .wide     (algo_is_wide(mode_q[ALGO_LSB +: 3])),
        .idx      (chain_idx),
        .state    (chain_state)
    );

    hctx_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_wr  (mode_wr),
        .lo_wr    (hit_lo && bus_wr),
        .hi_wr    (hit_hi && bus_wr),
        .wdata    (bus_wdata),
        .len_done (core_len_done),
        .len_in   (core_len_in),
        .mode     (mode_q),
        .len      (len_q)
    );

    hctx_chain #(.DATA_W(DATA_W), .MAX_WORDS(MAX_WORDS)) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (chain_go && bus_wr),
        .idx       (chain_idx),
        .wdata     (bus_wdata),
        .state_in  (core_state_in),
        .state_out (core_state_out),
        .rd_word   (chain_rd)
    );

    always_comb begin
        rd_mux = '0;
        if (hit_mode)        rd_mux = mode_q;
        else if (hit_chain)  rd_mux = core_busy ? '0 : chain_rd;
        else if (hit_status) rd_mux = DATA_W'(core_busy);
        else if (hit_lo)     rd_mux = len_q[DATA_W-1:0];
        else if (hit_hi)     rd_mux = len_q[2*DATA_W-1:DATA_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_sel && !bus_wr) begin
            rdata_q <= rd_mux;
        end
    end

    assign bus_rdata    = rdata_q;
    assign core_len_out = len_q;
    assign core_resume  = |len_q;
    assign mode_algo    = mode_q[ALGO_LSB +: 3];
    assign mode_hmac    = mode_q[HMAC_BIT];
    assign mode_endian  = mode_q[ENDIAN_LSB +: 6];

endmodule

// File: rtl/hctx_port_checker.sv
module hctx_port_checker
    import hctx_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned MAX_WORDS = 16,
    localparam int unsigned IDX_W = $clog2(MAX_WORDS)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        bus_sel,
    input logic                        bus_wr,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic [DATA_W-1:0]           bus_rdata,
    input logic                        core_busy,
    input logic                        core_len_done,
    input logic [2*DATA_W-1:0]         core_len_in,
    input logic [2*DATA_W-1:0]         core_len_out,
    input logic [MAX_WORDS*DATA_W-1:0] core_state_out,
    input logic [2:0]                  mode_algo,
    input logic [IDX_W-1:0]            idx
);

    logic chain_acc, len_bus_wr;
    assign chain_acc  = bus_sel && (bus_addr == ADDR_W'(OFF_CHAIN));
    assign len_bus_wr = bus_sel && bus_wr &&
                        ((bus_addr == ADDR_W'(OFF_LEN_LO)) || (bus_addr == ADDR_W'(OFF_LEN_HI)));

    a_r2_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        algo_is_wide(mode_algo) || (idx < IDX_W'(WORDS_NARROW)));

    a_r5_mode_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && (bus_addr == ADDR_W'(OFF_MODE))) |=> (idx == '0));

    a_r7_status_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && (bus_addr == ADDR_W'(OFF_STATUS))) |=>
        (bus_rdata == DATA_W'($past(core_busy))));

    a_r8_busy_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_acc && !bus_wr && core_busy) |=> (bus_rdata == '0));

    a_r8_busy_write_held: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_acc && bus_wr && core_busy) |=> $stable(core_state_out));

    a_r8_busy_index_held: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_acc && core_busy) |=> $stable(idx));

    a_r6_len_publish: assert property (@(posedge clk) disable iff (!rst_n)
        (core_len_done && !len_bus_wr) |=> (core_len_out == $past(core_len_in)));

endmodule

bind hctx_port hctx_port_checker #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MAX_WORDS(MAX_WORDS)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_sel        (bus_sel),
    .bus_wr         (bus_wr),
    .bus_addr       (bus_addr),
    .bus_rdata      (bus_rdata),
    .core_busy      (core_busy),
    .core_len_done  (core_len_done),
    .core_len_in    (core_len_in),
    .core_len_out   (core_len_out),
    .core_state_out (core_state_out),
    .mode_algo      (mode_algo),
    .idx            (chain_idx)
);

// File: tb/hctx_port_bench.sv
module hctx_port_bench;

    localparam int DW = 32;
    localparam int AW = 12;
    localparam int NW = 16;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic core_busy = 1'b0;
    logic [NW*DW-1:0] core_state_in = '0;
    logic core_len_done = 1'b0;
    logic [2*DW-1:0] core_len_in = '0;
    logic [NW*DW-1:0] core_state_out;
    logic [2*DW-1:0] core_len_out;
    logic core_resume;
    logic [2:0] mode_algo;
    logic mode_hmac;
    logic [5:0] mode_endian;

    hctx_port u_hctx_port (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_busy(core_busy), .core_state_in(core_state_in),
        .core_len_done(core_len_done), .core_len_in(core_len_in),
        .core_state_out(core_state_out), .core_len_out(core_len_out),
        .core_resume(core_resume), .mode_algo(mode_algo),
        .mode_hmac(mode_hmac), .mode_endian(mode_endian)
    );

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    logic [31:0] m_mode;
    logic [63:0] m_len;
    int          m_idx;
    logic [31:0] m_sh [NW];
    logic [31:0] m_rd;

    function automatic int m_words();
        return (m_mode[18:16] == 3'd2 || m_mode[18:16] == 3'd3) ? 16 : 8;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = '0; m_len = '0; m_idx = 0; m_rd = '0;
            foreach (m_sh[k]) m_sh[k] = '0;
        end else begin
            if (core_len_done) m_len = core_len_in;
            if (bus_sel && bus_wr) begin
                case (bus_addr)
                    12'h000: begin m_mode = bus_wdata; m_idx = 0; end
                    12'h004: if (!core_busy) begin
                        m_sh[m_idx] = bus_wdata;
                        m_idx = (m_idx + 1) % m_words();
                    end
                    12'h060: m_len[31:0]  = bus_wdata;
                    12'h064: m_len[63:32] = bus_wdata;
                    default: ;
                endcase
            end else if (bus_sel) begin
                case (bus_addr)
                    12'h000: m_rd = m_mode;
                    12'h004: if (core_busy) m_rd = '0;
                             else begin
                                 m_rd = core_state_in[m_idx*32 +: 32];
                                 m_idx = (m_idx + 1) % m_words();
                             end
                    12'h058: m_rd = {31'b0, core_busy};
                    12'h060: m_rd = m_len[31:0];
                    12'h064: m_rd = m_len[63:32];
                    default: m_rd = '0;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check({cur_req, " rdata"}, 64'(bus_rdata), 64'(m_rd));
            check({cur_req, " len"}, core_len_out, m_len);
            check({cur_req, " resume"}, 64'(core_resume), 64'(m_len != 0));
            check({cur_req, " mode"}, {mode_endian, mode_hmac, mode_algo},
                  {m_mode[31:26], m_mode[22], m_mode[18:16]});
            for (int k = 0; k < NW; k++)
                check({cur_req, " restore word"}, 64'(core_state_out[k*32 +: 32]), 64'(m_sh[k]));
        end
    end

    function automatic logic [31:0] pat(input int seed, input int k);
        return 32'hC0DE_0000 | 32'(seed << 8) | 32'(k);
    endfunction

    task automatic load_core(input int seed);
        for (int k = 0; k < NW; k++) core_state_in[k*32 +: 32] = pat(seed, k);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        check(tag, 64'(bus_rdata), 64'(exp));
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        cur_req = "R1";
        check("R1 rdata", 64'(bus_rdata), 64'h0);
        check("R1 len", core_len_out, 64'h0);
        check("R1 resume", 64'(core_resume), 64'h0);
        check("R1 mode", {mode_endian, mode_hmac, mode_algo}, 64'h0);
        check("R1 restore", core_state_out[63:0], 64'h0);

        // R5 mode fields
        cur_req = "R5";
        wr(12'h000, 32'hA843_0000);
        rd(12'h000, 32'hA843_0000, "R5 mode readback");
        check("R5 algo", 64'(mode_algo), 64'd3);
        check("R5 hmac", 64'(mode_hmac), 64'd1);
        check("R5 endian", 64'(mode_endian), 64'h2A);

        // R3 wide read stream, R2 wrap after 16
        cur_req = "R3";
        load_core(1);
        for (int k = 0; k < 16; k++) rd(12'h004, pat(1, k), "R3 wide read order");
        cur_req = "R2";
        rd(12'h004, pat(1, 0), "R2 wide wrap to word 0");

        // R2 narrow: wrap after 8
        wr(12'h000, 32'h0000_0000);
        load_core(2);
        for (int k = 0; k < 8; k++) rd(12'h004, pat(2, k), "R2 narrow read");
        rd(12'h004, pat(2, 0), "R2 narrow wrap to word 0");

        // R5 digest read of 7 words then rewind
        cur_req = "R5";
        wr(12'h000, 32'h0001_0000);
        for (int k = 0; k < 7; k++) rd(12'h004, pat(2, k), "R5 digest word");
        wr(12'h000, 32'h0001_0000);
        rd(12'h004, pat(2, 0), "R5 rewind after mode write");

        // R4 write stream
        cur_req = "R4";
        wr(12'h000, 32'h0004_0000);
        for (int k = 0; k < 8; k++) wr(12'h004, 32'h5500_0000 + 32'(k));
        for (int k = 0; k < 8; k++)
            check("R4 restore word", 64'(core_state_out[k*32 +: 32]), 64'(32'h5500_0000 + 32'(k)));
        wr(12'h004, 32'h0000_0077);
        check("R4 wrap writes word 0", 64'(core_state_out[31:0]), 64'h77);

        // R7 status, R8 busy behaviour (index now 1)
        cur_req = "R7";
        core_busy = 1'b1;
        rd(12'h058, 32'h1, "R7 status busy");
        cur_req = "R8";
        rd(12'h004, 32'h0, "R8 busy read zero");
        wr(12'h004, 32'hDEAD_BEEF);
        check("R8 busy write ignored", 64'(core_state_out[63:32]), 64'h5500_0001);
        core_busy = 1'b0;
        cur_req = "R7";
        rd(12'h058, 32'h0, "R7 status idle");
        cur_req = "R8";
        rd(12'h004, pat(2, 1), "R8 index held through busy");

        // R6 length
        cur_req = "R6";
        wr(12'h060, 32'h1234_5678);
        wr(12'h064, 32'h0000_0009);
        rd(12'h060, 32'h1234_5678, "R6 len lo");
        rd(12'h064, 32'h0000_0009, "R6 len hi");
        check("R6 len out", core_len_out, 64'h9_1234_5678);
        core_len_in = 64'h40; core_len_done = 1'b1;
        @(negedge clk);
        core_len_done = 1'b0;
        rd(12'h060, 32'h40, "R6 publish lo");
        rd(12'h064, 32'h0, "R6 publish hi");
        core_len_in = 64'hFFFF_FFFF_FFFF_FFFF; core_len_done = 1'b1;
        wr(12'h060, 32'h0000_0011);
        core_len_done = 1'b0;
        check("R6 bus write wins", core_len_out, 64'hFFFF_FFFF_0000_0011);

        // R9 resume
        cur_req = "R9";
        wr(12'h064, 32'h0);
        wr(12'h060, 32'h0);
        check("R9 zero length no resume", 64'(core_resume), 64'h0);
        wr(12'h064, 32'h1);
        check("R9 high word resume", 64'(core_resume), 64'h1);

        // R10 unmapped
        cur_req = "R10";
        rd(12'h010, 32'h0, "R10 unmapped read");
        rd(12'h404, 32'h0, "R10 unmapped high read");

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=complete");
            summary();
            $finish;
        end
    end

endmodule